// File: doc/BRIEF.md
# Output Voltage Window Monitor

This block watches a regulated output supply through digitised millivolt samples and decides whether the rail is healthy. It takes the programmed target voltage, derives a power-good window and an under-voltage limit from it as fixed percentages, and also compares every sample against one absolute over-voltage ceiling that does not depend on the target. The outcome is a level power-good flag plus one-cycle trip pulses for over-voltage and under-voltage, which a power-up sequencer consumes and latches.

Samples count only on cycles where the valid strobe is high. The sequencer gates two of the checks: power-good is forced low until its enable is set, and under-voltage is disregarded until the under-voltage enable is set. The over-voltage check is never gated. Each trip must persist across two consecutive valid samples before it is reported, so a single noisy sample cannot shut the supply down. Every ratio is computed by multiplying constants as shifts and adds and then comparing the scaled values, so the block contains no divider.

Top module: `ovm_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `pgood`, `ov_trip` and `uv_trip` are all 0.
- R2: With `pg_en` high, a valid sample whose value lies between floor(88·target/100) and floor(112·target/100), both ends inclusive, drives `pgood` to 1 on the cycle after the strobe's clock edge.
- R3: A valid sample above floor(112·target/100) drives `pgood` to 0 on the next cycle.
- R4: A valid sample below floor(88·target/100) drives `pgood` to 0 on the next cycle.
- R5: While `pg_en` is low, `pgood` is 0 one cycle later and stays 0 whatever samples arrive.
- R6: `pgood` changes only after a cycle with `sample_vld` high (or after a change of `pg_en`). Sample values on cycles with the strobe low have no effect.
- R7: A sample strictly above the absolute limit (2000 mV by default) on two consecutive valid strobes raises `ov_trip` for exactly one cycle, after the second strobe. This holds regardless of the target, `pg_en` and `uv_en`.
- R8: With `uv_en` high, a sample below floor(60·target/100) on two consecutive valid strobes raises `uv_trip` for one cycle, after the second strobe.
- R9: While `uv_en` is low, no `uv_trip` is produced and any partial under-voltage count is discarded.
- R10: A single offending sample never trips. A valid sample that does not offend restarts the count. Cycles with the strobe low between strobes neither advance nor reset it.
- R11: A trip pulses once per episode. Further offending samples give no new pulse until a non-offending valid sample re-arms the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_mv | input | 12 | Output-voltage sample in millivolts |
| sample_vld | input | 1 | Strobe marking `sample_mv` as a fresh sample |
| target_mv | input | 12 | Programmed target voltage in millivolts |
| pg_en | input | 1 | Power-good enable from the sequencer |
| uv_en | input | 1 | Under-voltage check enable from the sequencer |
| pgood | output | 1 | Output within window (registered level) |
| ov_trip | output | 1 | One-cycle over-voltage trip pulse |
| uv_trip | output | 1 | One-cycle under-voltage trip pulse |

## Verification
Suppose a persistence counter is corrupted, for example fails to clear on a clean sample or survives the disabling of under-voltage checks. The port then shows a trip after a single offending sample, or a missing trip after two, on the very next cycle after the offending strobe. The bench therefore places one clean strobe, or one enable drop, between offending strobes and checks each trip output on the cycle after every strobe. A wrong scaling constant moves a window edge. Checking targets of 1500 mV and 1237 mV one millivolt on each side of every edge shows that fault as a wrong `pgood` one cycle after the strobe.

// File: rtl/ovm_pkg.sv
package ovm_pkg;
    localparam int MV_W       = 12;
    localparam int PCT_BASE   = 100;
    localparam int PG_HI_PCT  = 112;
    localparam int PG_LO_PCT  = 88;
    localparam int UV_PCT     = 60;
    localparam int OV_DEF_MV  = 2000;
    localparam int TRIP_HITS  = 2;
endpackage

// File: rtl/ovm_scale.sv
// Constant multiplier built only from shifted copies of the input.
module ovm_scale #(
    parameter int IN_W  = 12,
    parameter int K     = 100,
    parameter int OUT_W = IN_W + 7
) (
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] y
);
    localparam int          KB = $clog2(K + 1);
    localparam logic [31:0] KV = 32'(K);

    logic [OUT_W-1:0] part [KB];

    generate
        for (genvar i = 0; i < KB; i++) begin : g_bit
            if (KV[i]) begin : g_on
                assign part[i] = OUT_W'(x) << i;
            end else begin : g_off
                assign part[i] = '0;
            end
        end
    endgenerate

    always_comb begin
        y = '0;
        for (int i = 0; i < KB; i++) begin
            y = y + part[i];
        end
    end
endmodule

// File: rtl/ovm_persist.sv
// Counts consecutive offending valid samples and emits one pulse per episode.
module ovm_persist #(
    parameter int HITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic arm,
    input  logic cond,
    output logic pulse
);
    localparam int CW = $clog2(HITS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!arm) begin
            st_d.cnt = '0;
        end else if (vld) begin
            if (cond) begin
                if (st_q.cnt != CW'(HITS)) st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(HITS - 1)) st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R11: one pulse, never two cycles in a row
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R10: a pulse always follows an armed valid strobe
    p_strobe_before_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> ($past(vld) && $past(arm)));
endmodule

// File: rtl/ovm_top.sv
module ovm_top
    import ovm_pkg::*;
#(
    parameter int W      = MV_W,
    parameter int OV_MV  = OV_DEF_MV,
    parameter int HITS   = TRIP_HITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample_mv,
    input  logic         sample_vld,
    input  logic [W-1:0] target_mv,
    input  logic         pg_en,
    input  logic         uv_en,
    output logic         pgood,
    output logic         ov_trip,
    output logic         uv_trip
);
    localparam int PW = W + 7;

    typedef struct packed {
        logic pgood;
    } st_t;

    st_t st_d, st_q;

    logic [PW-1:0] s_x100, s_next_x100, hi_lim, lo_lim, uv_lim;
    logic          above_hi, below_lo, below_uv, over_abs;

    ovm_scale #(.IN_W(W), .K(PCT_BASE),  .OUT_W(PW)) u_s  (.x(sample_mv), .y(s_x100));
    ovm_scale #(.IN_W(W), .K(PG_HI_PCT), .OUT_W(PW)) u_hi (.x(target_mv), .y(hi_lim));
    ovm_scale #(.IN_W(W), .K(PG_LO_PCT), .OUT_W(PW)) u_lo (.x(target_mv), .y(lo_lim));
    ovm_scale #(.IN_W(W), .K(UV_PCT),    .OUT_W(PW)) u_uv (.x(target_mv), .y(uv_lim));

    // s > floor(a*t/100)  <=>  100*s > a*t
    // s < floor(a*t/100)  <=>  100*(s+1) <= a*t
    assign s_next_x100 = s_x100 + PW'(PCT_BASE);
    assign above_hi    = s_x100 > hi_lim;
    assign below_lo    = s_next_x100 <= lo_lim;
    assign below_uv    = s_next_x100 <= uv_lim;
    assign over_abs    = sample_mv > W'(OV_MV);

    always_comb begin
        st_d = st_q;
        if (!pg_en)          st_d.pgood = 1'b0;
        else if (sample_vld) st_d.pgood = !above_hi && !below_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pgood = st_q.pgood;

    ovm_persist #(.HITS(HITS)) u_ov (
        .clk(clk), .rst_n(rst_n), .vld(sample_vld), .arm(1'b1),
        .cond(over_abs), .pulse(ov_trip));

    ovm_persist #(.HITS(HITS)) u_uv_p (
        .clk(clk), .rst_n(rst_n), .vld(sample_vld), .arm(uv_en),
        .cond(below_uv), .pulse(uv_trip));

    // R5: disabled power-good reads low next cycle
    p_pg_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_en |=> !pgood);
    // R6: no strobe, enable held: flag holds
    p_pg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_en && !sample_vld) |=> $stable(pgood));
    // R9: no under-voltage trip while the check is disabled
    p_uv_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_en |=> !uv_trip);
    // R7: over-voltage trip only after a strobe
    p_ov_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ov_trip |-> $past(sample_vld));
endmodule

// File: tb/tb_ovm_top.sv
`timescale 1ns/1ps
module tb_ovm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sample_mv = '0;
    logic        sample_vld = 1'b0;
    logic [11:0] target_mv = '0;
    logic        pg_en = 1'b0;
    logic        uv_en = 1'b0;
    logic        pgood, ov_trip, uv_trip;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    ovm_top dut (
        .clk(clk), .rst_n(rst_n), .sample_mv(sample_mv), .sample_vld(sample_vld),
        .target_mv(target_mv), .pg_en(pg_en), .uv_en(uv_en),
        .pgood(pgood), .ov_trip(ov_trip), .uv_trip(uv_trip));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic logic exp_pg(int s, int t);
        return (s <= (t * 112) / 100) && (s >= (t * 88) / 100);
    endfunction

    // one valid strobe; returns at the negedge where its effect is visible
    task automatic send(int s);
        @(negedge clk);
        sample_mv  = 12'(s);
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 pgood in reset", pgood, 1'b0);
        chk("R1 ov in reset", ov_trip, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pgood after reset", pgood, 1'b0);
        chk("R1 uv after reset", uv_trip, 1'b0);
    endtask

    task automatic t_window(int t);
        int pts [6];
        target_mv = 12'(t);
        pg_en = 1'b1;
        pts = '{(t * 112) / 100, (t * 112) / 100 + 1, (t * 88) / 100,
                (t * 88) / 100 - 1, t, (t * 112) / 100 + 40};
        foreach (pts[i]) begin
            send(pts[i]);
            if (pts[i] > (t * 112) / 100)      chk("R3 above high edge", pgood, exp_pg(pts[i], t));
            else if (pts[i] < (t * 88) / 100)  chk("R4 below low edge", pgood, exp_pg(pts[i], t));
            else                               chk("R2 inside window", pgood, exp_pg(pts[i], t));
        end
    endtask

    task automatic t_hold();
        target_mv = 12'd1500;
        pg_en = 1'b1;
        send(1500);
        chk("R2 in window", pgood, 1'b1);
        sample_mv = 12'd100;
        repeat (4) @(negedge clk);
        chk("R6 unstrobed sample ignored", pgood, 1'b1);
        send(1800);
        chk("R3 strobed high sample", pgood, 1'b0);
        sample_mv = 12'd1500;
        repeat (3) @(negedge clk);
        chk("R6 hold low without strobe", pgood, 1'b0);
    endtask

    task automatic t_pg_gate();
        target_mv = 12'd1500;
        pg_en = 1'b1;
        send(1500);
        chk("R2 enabled in window", pgood, 1'b1);
        @(negedge clk);
        pg_en = 1'b0;
        @(negedge clk);
        chk("R5 disable drops flag", pgood, 1'b0);
        send(1500);
        chk("R5 sample ignored while disabled", pgood, 1'b0);
        pg_en = 1'b1;
        @(negedge clk);
        chk("R5 enable alone does not raise", pgood, 1'b0);
        send(1500);
        chk("R2 re-enabled sample", pgood, 1'b1);
    endtask

    task automatic t_ov();
        pg_en = 1'b0;
        uv_en = 1'b0;
        target_mv = 12'd1000;
        send(2001);
        chk("R10 single ov sample no trip", ov_trip, 1'b0);
        send(2001);
        chk("R7 ov trip after second sample", ov_trip, 1'b1);
        @(negedge clk);
        chk("R7 ov pulse one cycle", ov_trip, 1'b0);
        send(2001);
        chk("R11 no repeat while offending", ov_trip, 1'b0);
        send(2000);
        chk("R7 limit itself not over", ov_trip, 1'b0);
        send(2001);
        chk("R11 re-armed first sample", ov_trip, 1'b0);
        send(2050);
        chk("R11 re-armed trip", ov_trip, 1'b1);
        send(1500);
        send(2100);
        send(1500);
        send(2100);
        chk("R10 interrupted count no trip", ov_trip, 1'b0);
        send(2100);
        chk("R10 consecutive after restart", ov_trip, 1'b1);
        send(1000);
    endtask

    task automatic t_uv();
        target_mv = 12'd1237;
        uv_en = 1'b1;
        send(742);
        send(742);
        chk("R8 at uv limit no trip", uv_trip, 1'b0);
        send(741);
        chk("R10 first uv sample", uv_trip, 1'b0);
        sample_mv = 12'd1200;
        repeat (3) @(negedge clk);
        send(741);
        chk("R10 gap without strobe keeps count", uv_trip, 1'b1);
        send(1237);
        uv_en = 1'b0;
        send(500);
        send(500);
        chk("R9 uv ignored when disabled", uv_trip, 1'b0);
        uv_en = 1'b1;
        send(500);
        chk("R9 count discarded while disabled", uv_trip, 1'b0);
        @(negedge clk);
        uv_en = 1'b0;
        @(negedge clk);
        uv_en = 1'b1;
        send(500);
        chk("R9 disable clears partial count", uv_trip, 1'b0);
        send(500);
        chk("R8 uv trip", uv_trip, 1'b1);
        chk("R7 ov quiet during uv", ov_trip, 1'b0);
    endtask

    initial begin
        t_reset();
        t_window(1500);
        t_window(1237);
        t_hold();
        t_pg_gate();
        t_ov();
        t_uv();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule